// File: doc/BRIEF.md
# SAR Converter Conversion Sequencer

This block is the digital controller of a successive-approximation analog-to-digital converter. Everything runs on an external data clock, and an active-low chip select frames each conversion. When chip select falls, the block opens a short input-sampling window. It then runs a binary search one bit per clock. On each step it drives a trial code to an external capacitor DAC and reads back a single comparator decision. Each decided bit goes onto the serial output at the falling clock edge that resolves it, so there is no pipeline delay. The word is sent most significant bit first, in two's complement.

Once the last bit has been decided, further clocks replay the word least significant bit first. The serial output is then released and the block ignores clocks until chip select is cycled. Taking chip select high at any point aborts the conversion and releases the line at once, so a host that only needs the upper bits can stop early. The block also drives separate power-down indications for the analog section and the digital section.

Top module: `sar_conv_seq`

## Requirements
- R1: From the falling edge of `cs_n` until the second falling `dclk` edge after it, `sample_en` is 1 and `dout_oe` is 0.
- R2: At the second falling `dclk` edge after `cs_n` falls, `dout_oe` becomes 1 and `dout` drives a single 0 (null bit) for one clock period.
- R3: On falling edges 3 to 14 after `cs_n` falls, `dout` carries the result bits 11 down to 0. Each bit appears at the edge on which it is decided, and bit 11 is the two's-complement sign.
- R4: During the null-bit period, `dac_code` is 800h (offset binary). Comparator value 1 at a decision edge keeps the trial bit, and the next lower bit is then set to 1. The result is therefore the largest offset code that the comparator accepts.
- R5: On falling edges 15 to 25 after `cs_n` falls, `dout` carries result bits 1 up to 11. At edge 26 `dout_oe` returns to 0.
- R6: Once the output has been released, further `dclk` edges with `cs_n` low leave `dout_oe` at 0. A new conversion starts only after `cs_n` has gone high and then low again.
- R7: While `cs_n` is 1, `dout_oe` is 0. Raising `cs_n` mid-conversion releases the output without waiting for a clock edge.
- R8: `apd` is 1 while `cs_n` is 1, and from the edge that decides bit 0 until `cs_n` rises. `apd` is 0 during sampling and bit decisions. `dpd` equals `cs_n`.
- R9: The result is two's complement: offset code 000h gives 800h, 800h gives 000h, FFFh gives 7FFh and 7FFh gives FFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | External data clock; all state changes on its falling edge |
| cs_n | input | 1 | Active-low chip select; high aborts and clears the conversion |
| cmp_hi | input | 1 | Comparator result: 1 when the sampled input is at or above the trial level |
| dac_code | output | 12 | Trial code to the capacitor DAC, offset binary |
| sample_en | output | 1 | High during the input-sampling window |
| dout | output | 1 | Serial data value |
| dout_oe | output | 1 | Serial data drive enable; 0 means high impedance |
| apd | output | 1 | Analog section power-down |
| dpd | output | 1 | Digital section power-down |

## Verification
The comparator is modelled as a threshold on a hidden offset-binary target. Each target produces one expected word. The targets are the two full-scale ends, the codes on either side of midscale, and two irregular bit patterns. The end codes tell a missing MSB inversion apart from a correct search. The codes around midscale expose an off-by-one in the decision order. The irregular patterns catch swapped indices in the MSB-first stream and in the LSB-first replay. Directed runs cover a conversion cut short after eight bits followed by a clean restart, and extra clocks after the line has been released.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   // What the next falling data-clock edge does
   typedef enum logic [2:0] {
      EK_NONE   = 3'd0,
      EK_NULL   = 3'd1,
      EK_DECIDE = 3'd2,
      EK_REPLAY = 3'd3,
      EK_OFF    = 3'd4
   } edge_kind_e;

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
   import sar_seq_pkg::*;
#(
   parameter  int N_BITS   = 12,
   parameter  int SMP_EDGES = 2,
   localparam int LAST_CNT = SMP_EDGES + 2 * N_BITS,
   localparam int CW       = $clog2(LAST_CNT + 1)
) (
   input  logic          dclk,
   input  logic          cs_n,
   output edge_kind_e    kind,
   output logic [CW-1:0] idx,
   output logic          sample_en,
   output logic          apd
);

   if (SMP_EDGES < 1) begin : g_bad_smp
      $error("SMP_EDGES must be at least 1");
   end

   localparam logic [CW-1:0] C_NULL   = CW'(SMP_EDGES - 1);
   localparam logic [CW-1:0] C_DEC0   = CW'(SMP_EDGES);
   localparam logic [CW-1:0] C_DECL   = CW'(SMP_EDGES + N_BITS - 1);
   localparam logic [CW-1:0] C_REP0   = CW'(SMP_EDGES + N_BITS);
   localparam logic [CW-1:0] C_OFF    = CW'(SMP_EDGES + 2 * N_BITS - 1);
   localparam logic [CW-1:0] C_LAST   = CW'(LAST_CNT);

   // Count of falling edges seen since chip select fell, saturating
   logic [CW-1:0] cnt;

   always_ff @(negedge dclk or posedge cs_n) begin
      if (cs_n)
         cnt <= '0;
      else if (cnt != C_LAST)
         cnt <= cnt + 1'b1;
   end

   // Decode of the coming edge from the current count
   always_comb begin
      kind = EK_NONE;
      idx  = '0;
      if (cnt == C_NULL) begin
         kind = EK_NULL;
      end else if (cnt >= C_DEC0 && cnt <= C_DECL) begin
         kind = EK_DECIDE;
         idx  = C_DECL - cnt;
      end else if (cnt >= C_REP0 && cnt < C_OFF) begin
         kind = EK_REPLAY;
         idx  = cnt - C_DECL;
      end else if (cnt == C_OFF) begin
         kind = EK_OFF;
      end
   end

   assign sample_en = !cs_n && (cnt < C_DEC0);
   assign apd       = cs_n || (cnt >= C_REP0);

   // Once finished, clocks no longer move the sequence
   assert_cnt_hold_R6: assert property (@(posedge dclk) disable iff (cs_n)
      (cnt == C_LAST) |=> (cnt == C_LAST));

   // Analog stays down once the last bit is decided
   assert_apd_hold_R8: assert property (@(posedge dclk) disable iff (cs_n)
      apd |=> apd);

endmodule

// File: rtl/sar_seq_areg.sv
module sar_seq_areg
   import sar_seq_pkg::*;
#(
   parameter  int N_BITS = 12,
   parameter  int CW     = 5
) (
   input  logic              dclk,
   input  logic              cs_n,
   input  edge_kind_e        kind,
   input  logic [CW-1:0]     idx,
   input  logic              cmp_hi,
   output logic [N_BITS-1:0] trial,
   output logic [N_BITS-1:0] res_tc,
   output logic              dec_bit
);

   if (N_BITS < 2) begin : g_bad_bits
      $error("N_BITS must be at least 2");
   end

   for (genvar i = 0; i < N_BITS; i++) begin : g_bit
      logic b;
      always_ff @(negedge dclk or posedge cs_n) begin
         if (cs_n) begin
            b <= 1'b0;
         end else begin
            case (kind)
               EK_NULL:   b <= (i == N_BITS - 1);
               EK_DECIDE: begin
                  if (idx == CW'(i))
                     b <= cmp_hi;
                  else if (idx == CW'(i + 1))
                     b <= 1'b1;
               end
               default:   b <= b;
            endcase
         end
      end
      assign trial[i] = b;
   end

   // Offset binary to two's complement: flip the top bit
   assign res_tc  = {~trial[N_BITS-1], trial[N_BITS-2:0]};
   assign dec_bit = (idx == CW'(N_BITS - 1)) ? ~cmp_hi : cmp_hi;

endmodule

// File: rtl/sar_seq_shift.sv
module sar_seq_shift
   import sar_seq_pkg::*;
#(
   parameter  int N_BITS = 12,
   parameter  int CW     = 5
) (
   input  logic              dclk,
   input  logic              cs_n,
   input  edge_kind_e        kind,
   input  logic [CW-1:0]     idx,
   input  logic              dec_bit,
   input  logic [N_BITS-1:0] res_tc,
   output logic              dout,
   output logic              dout_oe
);

   logic rep_bit;

   always_comb begin
      rep_bit = 1'b0;
      for (int k = 0; k < N_BITS; k++) begin
         if (idx == CW'(k))
            rep_bit = res_tc[k];
      end
   end

   always_ff @(negedge dclk or posedge cs_n) begin
      if (cs_n) begin
         dout    <= 1'b0;
         dout_oe <= 1'b0;
      end else begin
         case (kind)
            EK_NULL: begin
               dout    <= 1'b0;
               dout_oe <= 1'b1;
            end
            EK_DECIDE: dout <= dec_bit;
            EK_REPLAY: dout <= rep_bit;
            EK_OFF: begin
               dout    <= 1'b0;
               dout_oe <= 1'b0;
            end
            default: begin
               dout    <= dout;
               dout_oe <= dout_oe;
            end
         endcase
      end
   end

   // The enable may only rise at the null bit, which drives low
   assert_null_low_R2: assert property (@(posedge dclk) disable iff (cs_n)
      $rose(dout_oe) |-> !dout);

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
   import sar_seq_pkg::*;
#(
   parameter  int N_BITS    = 12,
   parameter  int SMP_EDGES = 2,
   localparam int CW        = $clog2(SMP_EDGES + 2 * N_BITS + 1)
) (
   input  logic              dclk,
   input  logic              cs_n,
   input  logic              cmp_hi,
   output logic [N_BITS-1:0] dac_code,
   output logic              sample_en,
   output logic              dout,
   output logic              dout_oe,
   output logic              apd,
   output logic              dpd
);

   edge_kind_e        kind;
   logic [CW-1:0]     idx;
   logic [N_BITS-1:0] res_tc;
   logic              dec_bit;

   sar_seq_ctrl #(.N_BITS(N_BITS), .SMP_EDGES(SMP_EDGES)) u_ctrl (
      .dclk      (dclk),
      .cs_n      (cs_n),
      .kind      (kind),
      .idx       (idx),
      .sample_en (sample_en),
      .apd       (apd)
   );

   sar_seq_areg #(.N_BITS(N_BITS), .CW(CW)) u_areg (
      .dclk    (dclk),
      .cs_n    (cs_n),
      .kind    (kind),
      .idx     (idx),
      .cmp_hi  (cmp_hi),
      .trial   (dac_code),
      .res_tc  (res_tc),
      .dec_bit (dec_bit)
   );

   sar_seq_shift #(.N_BITS(N_BITS), .CW(CW)) u_shift (
      .dclk    (dclk),
      .cs_n    (cs_n),
      .kind    (kind),
      .idx     (idx),
      .dec_bit (dec_bit),
      .res_tc  (res_tc),
      .dout    (dout),
      .dout_oe (dout_oe)
   );

   assign dpd = cs_n;

   // Search starts at midscale when the line is first driven
   assert_trial_mid_R4: assert property (@(posedge dclk) disable iff (cs_n)
      $rose(dout_oe) |-> (dac_code == N_BITS'(1 << (N_BITS - 1))));

   assert_sample_quiet_R1: assert property (@(posedge dclk) disable iff (cs_n)
      sample_en |-> !dout_oe);

   assert_idle_hiz_R7: assert property (@(posedge dclk)
      cs_n |-> !dout_oe);

endmodule

// File: tb/tb_sar_conv_seq.sv
module tb_sar_conv_seq;

   localparam int CLK_PERIOD = 10;
   localparam int NB = 12;
   localparam int SE = 2;

   logic          dclk = 1'b1;
   logic          cs_n = 1'b1;
   logic [NB-1:0] target = '0;
   logic [NB-1:0] dac_code;
   logic          cmp_hi, sample_en, dout, dout_oe, apd, dpd;

   int n_run  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) dclk = ~dclk;

   // Comparator model: input at or above the trial level
   assign cmp_hi = (dac_code <= target);

   sar_conv_seq dut (
      .dclk      (dclk),
      .cs_n      (cs_n),
      .cmp_hi    (cmp_hi),
      .dac_code  (dac_code),
      .sample_en (sample_en),
      .dout      (dout),
      .dout_oe   (dout_oe),
      .apd       (apd),
      .dpd       (dpd)
   );

   // {offset target, expected two's-complement word}
   localparam logic [23:0] VEC [6] = '{
      {12'h000, 12'h800},
      {12'hFFF, 12'h7FF},
      {12'h800, 12'h000},
      {12'h7FF, 12'hFFF},
      {12'hA5A, 12'h25A},
      {12'h123, 12'h923}
   };

   task automatic chk(input string tag, input logic [NB-1:0] got, input logic [NB-1:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge dclk);
      #1;
   endtask

   // stop_after > 0: raise chip select after that many decided bits
   task automatic run_conv(input logic [NB-1:0] tgt, input logic [NB-1:0] expw,
                           input int stop_after);
      target = tgt;
      step();
      cs_n = 1'b0;
      #1;
      chk("R1 sample_en at start", {11'b0, sample_en}, 12'd1);
      chk("R1 oe at start", {11'b0, dout_oe}, 12'd0);
      chk("R8 apd at start", {11'b0, apd}, 12'd0);
      for (int e = 1; e <= SE + 2 * NB + 3; e++) begin
         step();
         if (e < SE) begin
            chk("R1 sample_en", {11'b0, sample_en}, 12'd1);
            chk("R1 oe", {11'b0, dout_oe}, 12'd0);
         end else if (e == SE) begin
            chk("R2 oe null", {11'b0, dout_oe}, 12'd1);
            chk("R2 dout null", {11'b0, dout}, 12'd0);
            chk("R4 dac mid", dac_code, 12'h800);
            chk("R1 sample end", {11'b0, sample_en}, 12'd0);
         end else if (e <= SE + NB) begin
            chk("R3 msb-first bit", {11'b0, dout}, {11'b0, expw[SE + NB - e]});
            chk("R3 oe", {11'b0, dout_oe}, 12'd1);
            if (e == SE + 1)
               chk("R4 dac step", {10'b0, dac_code[NB-1:NB-2]}, {10'b0, tgt[NB-1], 1'b1});
            chk("R8 apd", {11'b0, apd}, {11'b0, (e == SE + NB)});
            if (stop_after > 0 && e == SE + stop_after) break;
         end else if (e < SE + 2 * NB) begin
            chk("R5 lsb-first bit", {11'b0, dout}, {11'b0, expw[e - SE - NB]});
            chk("R5 oe", {11'b0, dout_oe}, 12'd1);
         end else begin
            chk("R6 oe released", {11'b0, dout_oe}, 12'd0);
            chk("R8 apd done", {11'b0, apd}, 12'd1);
         end
      end
      cs_n = 1'b1;
      #1;
      chk("R7 oe cs high", {11'b0, dout_oe}, 12'd0);
      chk("R8 apd cs high", {11'b0, apd}, 12'd1);
      chk("R8 dpd cs high", {11'b0, dpd}, 12'd1);
      chk("R1 sample off", {11'b0, sample_en}, 12'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) step();
      // Reset state with chip select high
      chk("R7 reset oe", {11'b0, dout_oe}, 12'd0);
      chk("R8 reset apd", {11'b0, apd}, 12'd1);
      chk("R8 reset dpd", {11'b0, dpd}, 12'd1);
      chk("R1 reset sample", {11'b0, sample_en}, 12'd0);

      // R9 vectors
      for (int v = 0; v < 6; v++)
         run_conv(VEC[v][23:12], VEC[v][11:0], 0);

      // R7 short cycle after eight bits, then R6 clean restart
      run_conv(12'h3C5, 12'hBC5, 8);
      step();
      chk("R7 oe after abort", {11'b0, dout_oe}, 12'd0);
      run_conv(12'h801, 12'h001, 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule